// File: doc/BRIEF.md
# Smart Switch Operating Mode Supervisor

This block supervises the operating mode of a two-channel high-side power switch. It watches a combined reset/enable line, one wake line per channel, digital supply-good flags for the power rail and the logic rail, a fault summary flag, and a strobe that pulses once for every valid serial access. From these it keeps the switch in one of four modes: Sleep, Normal, Fail-safe or Fault. It reports the mode as a two-bit code and raises a Normal status bit.

Leaving Sleep sends a one-cycle reset to the configuration registers elsewhere in the chip. A ready flag rises after a programmable settling time. When the enable line is high, the switch is under serial control. In that case, serial accesses must keep arriving: a watchdog counts cycles spent in Normal without any access. When the watchdog expires, the block drops to Fail-safe and stays there until the part goes back to Sleep. A raised fault flag overrides every awake mode. When the fault clears, the block returns to the mode it left.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mode_o` is 00, and `normal_o`, `cfg_rst_o` and `ready_o` are 0.
- R2: The mode codes are 00 Sleep, 01 Normal, 10 Fail-safe and 11 Fault. The block is awake when `en_i` is high or either bit of `dwake_i` is high. At a clock edge in Sleep with the block awake, the mode becomes Normal, or Fault if `fault_i` is high.
- R3: `cfg_rst_o` is high for exactly the one cycle that follows a Sleep-to-awake edge, and is low at all other times.
- R4: At any clock edge where `en_i` is low and both `dwake_i` bits are low, the mode becomes Sleep, whatever the current mode.
- R5: At any awake clock edge where `fault_i` is high, the mode becomes Fault (11).
- R6: At an awake clock edge in Fault with `fault_i` low, the mode becomes Fail-safe if the watchdog has expired since the last wake-up, and Normal otherwise.
- R7: In Normal with `en_i` high, each edge without `acc_stb_i` advances a watchdog count. When the count is WDOG_CYCLES-1, an edge with no strobe moves the block to Fail-safe. So WDOG_CYCLES strobe-free edges in Normal cause expiry. A strobe, a low `en_i`, or any mode other than Normal clears the count.
- R8: Fail-safe is left only for Sleep (R4) or Fault (R5).
- R9: `normal_o` is high exactly when the mode is Normal, `pwr_ok_i` is high, and either `logic_ok_i` is high or `en_i` is low. It follows these inputs within the same cycle.
- R10: `ready_o` becomes 1 at the READY_CYCLES-th awake edge after the wake edge. It stays 1 while the block remains awake and clears when the block returns to Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Reset/enable line; high means serial control |
| dwake_i | input | 2 | Per-channel direct-input wake lines |
| pwr_ok_i | input | 1 | Power rail within range |
| logic_ok_i | input | 1 | Logic rail within range |
| fault_i | input | 1 | Fault summary flag |
| acc_stb_i | input | 1 | One pulse per valid serial access |
| mode_o | output | 2 | Current mode code |
| normal_o | output | 1 | Normal-mode status |
| cfg_rst_o | output | 1 | Configuration register reset pulse |
| ready_o | output | 1 | Settling delay elapsed since wake-up |

## Verification
A wrong mode register appears on `mode_o` one cycle after the edge that should have set it. A watchdog count that is off by one moves the Fail-safe transition by a single cycle, and an edge-exact comparison catches that. A lost Fail-safe memory shows only when a fault clears, as a return to Normal instead of Fail-safe, so the stimulus mixes faults with watchdog expiries. A miscounted settling delay moves the rise of `ready_o` by cycles.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int WDOG_CYCLES  = 5000,
  parameter int READY_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] dwake_i,
  input  logic       pwr_ok_i,
  input  logic       logic_ok_i,
  input  logic       fault_i,
  input  logic       acc_stb_i,
  output logic [1:0] mode_o,
  output logic       normal_o,
  output logic       cfg_rst_o,
  output logic       ready_o
);
  localparam logic [1:0] M_SLEEP = 2'b00, M_NORMAL = 2'b01, M_FSAFE = 2'b10, M_FAULT = 2'b11;
  localparam int WW = $clog2(WDOG_CYCLES + 1);
  localparam int RW = $clog2(READY_CYCLES + 1);

  logic [1:0]    mode_q, mode_d;
  logic          fs_q, fs_d;
  logic [WW-1:0] wd_q;
  logic [RW-1:0] rc_q;
  logic          ready_q, rst_q;

  wire awake  = en_i | (|dwake_i);
  wire wd_run = (mode_q == M_NORMAL) & en_i & ~acc_stb_i;
  wire wd_exp = wd_run & (wd_q == WW'(WDOG_CYCLES - 1));

  always_comb begin
    mode_d = mode_q;
    fs_d   = fs_q;
    if (!awake) begin
      mode_d = M_SLEEP;
      fs_d   = 1'b0;
    end else if (mode_q == M_SLEEP) begin
      mode_d = fault_i ? M_FAULT : M_NORMAL;
    end else if (fault_i) begin
      mode_d = M_FAULT;
    end else if (wd_exp) begin
      mode_d = M_FSAFE;
      fs_d   = 1'b1;
    end else if (mode_q == M_FAULT) begin
      mode_d = fs_q ? M_FSAFE : M_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_SLEEP;
      fs_q    <= 1'b0;
      wd_q    <= '0;
      rc_q    <= '0;
      ready_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      fs_q   <= fs_d;
      rst_q  <= (mode_q == M_SLEEP) & awake;
      wd_q   <= (wd_run && mode_d == M_NORMAL) ? wd_q + 1'b1 : '0;
      if (!awake || mode_q == M_SLEEP) begin
        rc_q    <= '0;
        ready_q <= 1'b0;
      end else if (!ready_q) begin
        if (rc_q == RW'(READY_CYCLES - 1)) ready_q <= 1'b1;
        else rc_q <= rc_q + 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign cfg_rst_o = rst_q;
  assign ready_o   = ready_q;
  assign normal_o  = (mode_q == M_NORMAL) & pwr_ok_i & (logic_ok_i | ~en_i);

  a_r3_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_SLEEP && awake) |=> cfg_rst_o);
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst_o |=> !cfg_rst_o);
  a_r4_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> mode_o == M_SLEEP);
  a_r5_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && fault_i) |=> mode_o == M_FAULT);
  a_r8_fs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_FSAFE && awake && !fault_i) |=> mode_o == M_FSAFE);
  a_r9_normal: assert property (@(posedge clk) disable iff (!rst_n)
    normal_o |-> (mode_o == M_NORMAL && pwr_ok_i));
  a_r10_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && awake && mode_o != M_SLEEP) |=> ready_o);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int W = 20;
  localparam int R = 12;
  localparam logic [1:0] S = 2'b00, N = 2'b01, F = 2'b10, X = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, pok = 0, lok = 0, flt = 0, stb = 0;
  logic [1:0] dw = 0;
  logic [1:0] mode;
  logic normal, cfgr, rdy;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.WDOG_CYCLES(W), .READY_CYCLES(R)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dwake_i(dw), .pwr_ok_i(pok),
    .logic_ok_i(lok), .fault_i(flt), .acc_stb_i(stb),
    .mode_o(mode), .normal_o(normal), .cfg_rst_o(cfgr), .ready_o(rdy));

  logic [1:0] e_mode = S, e_prev = S;
  logic e_fs = 0, e_rst = 0, e_rdy = 0;
  int e_wd = 0, e_rc = 0;

  always @(posedge clk) begin
    logic wk;
    wk = en | dw[0] | dw[1];
    if (!rst_n) begin
      e_mode <= S; e_prev <= S; e_fs <= 0; e_rst <= 0; e_rdy <= 0; e_wd <= 0; e_rc <= 0;
    end else begin
      e_prev <= e_mode;
      e_rst  <= (e_mode == S) && wk;
      if (!wk) begin e_mode <= S; e_fs <= 0; e_wd <= 0; end
      else if (e_mode == S) begin e_mode <= flt ? X : N; e_wd <= 0; end
      else if (flt) begin e_mode <= X; e_wd <= 0; end
      else if (e_mode == N && en && !stb) begin
        if (e_wd == W - 1) begin e_mode <= F; e_fs <= 1; e_wd <= 0; end
        else e_wd <= e_wd + 1;
      end else begin
        e_wd <= 0;
        if (e_mode == X) e_mode <= e_fs ? F : N;
      end
      if (!wk || e_mode == S) begin e_rc <= 0; e_rdy <= 0; end
      else if (!e_rdy) begin
        if (e_rc == R - 1) e_rdy <= 1; else e_rc <= e_rc + 1;
      end
    end
  end

  function automatic string mode_tag(logic [1:0] m, logic [1:0] p);
    if (m == S) return "R4";
    if (m == X) return "R5";
    if (m == F) return (p == F) ? "R8" : "R7";
    if (p == X) return "R6";
    return "R2";
  endfunction

  function automatic logic exp_normal();
    return (e_mode == N) && pok && (lok || !en);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(mode_tag(e_mode, e_prev), mode, e_mode);
    chk("R9", normal, exp_normal());
    chk("R3", cfgr, e_rst);
    chk("R10", rdy, e_rdy);
  endtask

  task automatic drive(logic a, logic [1:0] b, logic c, logic d, logic e, logic f);
    en = a; dw = b; pok = c; lok = d; flt = e; stb = f;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", mode, 0); chk("R1", normal, 0); chk("R1", cfgr, 0); chk("R1", rdy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", mode, 0); chk("R1", cfgr, 0);
    // direct-input wake only: watchdog must never expire (R7)
    drive(0, 2'b10, 1, 0, 0, 0);
    for (int i = 0; i < 3 * W; i++) begin @(negedge clk); check_all(); end
    chk("R7", mode, N);
    chk("R9", normal, 1);
    // serial control, no strobes: expiry, then fault, then fault release (R6)
    drive(1, 2'b00, 1, 1, 0, 0);
    for (int i = 0; i < W + 2; i++) begin @(negedge clk); check_all(); end
    chk("R7", mode, F);
    flt = 1; @(negedge clk); check_all();
    flt = 0; @(negedge clk); check_all();
    chk("R6", mode, F);
    drive(0, 2'b00, 1, 1, 0, 0); @(negedge clk); check_all();
    chk("R4", mode, S);
    // randomized phases
    for (int i = 0; i < 8000; i++) begin
      int ph;
      ph = (i / 400) % 4;
      drive(($urandom % 100) < (ph == 3 ? 60 : 92),
            {($urandom % 4) == 0, ($urandom % 4) == 0},
            ($urandom % 8) != 0, ($urandom % 8) != 0,
            ($urandom % 100) < (ph == 2 ? 20 : 2),
            ($urandom % 100) < (ph == 1 ? 3 : 25));
      @(negedge clk);
      check_all();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule